// File: doc/BRIEF.md
# Host Sector Erase Sequencer

This block sits on the host side of a byte-wide flash bus and erases a list of sectors. The sector indices arrive one at a time over a valid/ready handshake. Each item carries a flag that marks the final entry of the list. For the first item, the sequencer writes the five-cycle erase preamble. It then writes one sector cycle, which carries the sector address and the confirm data byte. Further sectors are added to the same erase by writing more sector cycles back to back. Between those cycles the sequencer reads status to find out whether the device's add-sector window has closed.

The sequencer stops adding sectors in three cases: the list ends, the window-closed bit reads set, or the host leaves the window idle for too long. It then polls status until the toggle bit stops. If the failure bit is seen while the toggle bit is still moving, one more read decides between success and error. When an erase is cut short, the sectors not yet accepted stay pending on the handshake. The sequencer then starts a fresh full command sequence for them without outside help.

Top module: `sector_erase_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, bus_we, bus_oe, s_ready, done, err and gap_viol are all low.
- R2: An erase sequence starts with five consecutive write cycles, with (address, data) equal to (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), in that order.
- R3: Each accepted sector is written in a single write cycle. In that cycle the address is the index shifted left by SEC_SHIFT, the data is 0x30, and s_ready is high. s_ready is high in no other cycle.
- R4: After a sector whose last flag is low, the block reads status once per cycle at that sector's address. The next sector is written in the cycle after a read that finds s_valid high.
- R5: When a window status read returns bit 3 set, no further sector is written in this sequence, and the item on the handshake stays unaccepted.
- R6: Once the window is closed, status is read every cycle. When two consecutive reads have the same bit 6, done pulses high for one cycle.
- R7: If s_valid is high when a sequence ends, a new sequence starts with the full five-cycle preamble, as in R2.
- R8: If a poll read shows bit 6 changed and bit 5 set, exactly one more read follows. If bit 6 has changed again in that read, err pulses high for one cycle and done stays low.
- R9: If bit 6 does not change in that extra read, done pulses instead of err.
- R10: If GAP_LIM consecutive window reads pass without s_valid, gap_viol pulses for one cycle, the window closes, and polling begins.
- R11: bus_we and bus_oe are never high in the same cycle, and done and err never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | A sector index is offered |
| s_idx | input | ADDR_W-SEC_SHIFT | Sector index |
| s_last | input | 1 | Offered sector is the final one of the list |
| s_ready | output | 1 | Offered sector is accepted this cycle |
| bus_we | output | 1 | Bus write strobe, one cycle per write |
| bus_oe | output | 1 | Bus read strobe, one cycle per read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, sampled at the end of a read cycle |
| done | output | 1 | One-cycle pulse: erase finished normally |
| err | output | 1 | One-cycle pulse: erase failure confirmed |
| gap_viol | output | 1 | One-cycle pulse: host left the add-sector window idle too long |

## Verification
On every cycle, the assertions check four things: the two strobes never overlap, s_ready appears only during a 0x30 write, a set window-closed bit is never followed by another sector write, and done and err are exclusive and each follows a status read. A gap violation must also be followed straight away by polling. Only the bench's scenarios can show the exact order of the preamble writes and the batching of several sectors into one erase. The same holds for leaving a sector pending and reissuing it after a window closes. The bench also covers the two outcomes of the confirming read and the idle-window limit, using a reactive flash model.

// File: rtl/sector_erase_seq.sv
module sector_erase_seq #(
  parameter int ADDR_W    = 18,
  parameter int SEC_SHIFT = 14,
  parameter int GAP_LIM   = 2000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s_valid,
  input  logic [ADDR_W-SEC_SHIFT-1:0] s_idx,
  input  logic                        s_last,
  output logic                        s_ready,
  output logic                        bus_we,
  output logic                        bus_oe,
  output logic [ADDR_W-1:0]           bus_addr,
  output logic [7:0]                  bus_wdata,
  input  logic [7:0]                  bus_rdata,
  output logic                        done,
  output logic                        err,
  output logic                        gap_viol
);
  localparam int GAP_W = $clog2(GAP_LIM + 1);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(12'h2AA);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_SEC, S_WIN, S_POLL, S_CONF} st_t;

  st_t                st;
  logic [2:0]         step;
  logic [ADDR_W-1:0]  sec_addr;
  logic [GAP_W-1:0]   gap;
  logic               prev_t, have_prev;
  logic [ADDR_W+7:0]  cmd_word;

  always_comb begin
    case (step)
      3'd0:    cmd_word = {ADR_A, 8'hAA};
      3'd1:    cmd_word = {ADR_B, 8'h55};
      3'd2:    cmd_word = {ADR_A, 8'h80};
      3'd3:    cmd_word = {ADR_A, 8'hAA};
      default: cmd_word = {ADR_B, 8'h55};
    endcase
  end

  assign bus_we    = (st == S_CMD) || (st == S_SEC);
  assign bus_oe    = (st == S_WIN) || (st == S_POLL) || (st == S_CONF);
  assign s_ready   = (st == S_SEC);
  assign bus_addr  = (st == S_CMD) ? cmd_word[ADDR_W+7:8] :
                     (st == S_SEC) ? {s_idx, {SEC_SHIFT{1'b0}}} :
                     bus_oe        ? sec_addr : '0;
  assign bus_wdata = (st == S_CMD) ? cmd_word[7:0] :
                     (st == S_SEC) ? 8'h30 : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      step      <= '0;
      sec_addr  <= '0;
      gap       <= '0;
      prev_t    <= 1'b0;
      have_prev <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      gap_viol  <= 1'b0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      gap_viol <= 1'b0;
      case (st)
        S_IDLE: if (s_valid) begin
          st   <= S_CMD;
          step <= '0;
        end
        S_CMD: begin
          if (step == 3'd4) st <= S_SEC;
          else step <= step + 3'd1;
        end
        S_SEC: begin
          sec_addr  <= bus_addr;
          gap       <= '0;
          have_prev <= 1'b0;
          st        <= s_last ? S_POLL : S_WIN;
        end
        S_WIN: begin
          if (bus_rdata[3]) st <= S_POLL;
          else if (s_valid) st <= S_SEC;
          else if (gap == GAP_W'(GAP_LIM - 1)) begin
            gap_viol <= 1'b1;
            st       <= S_POLL;
          end else gap <= gap + 1'b1;
        end
        S_POLL: begin
          have_prev <= 1'b1;
          prev_t    <= bus_rdata[6];
          if (have_prev && bus_rdata[6] == prev_t) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (have_prev && bus_rdata[5]) st <= S_CONF;
        end
        S_CONF: begin
          if (bus_rdata[6] == prev_t) done <= 1'b1;
          else err <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_oe));
  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_ready_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (bus_we && bus_wdata == 8'h30));
  p_window_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && bus_rdata[3]) |=> !bus_we);
  p_done_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_oe));
  p_err_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(bus_oe));
  p_gap_polls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_viol |-> (bus_oe && !s_ready));
endmodule

// File: tb/sector_erase_seq_tb_top.sv
module sector_erase_seq_tb_top;
  localparam int ADDR_W = 18, SEC_SHIFT = 14, GAP_LIM = 2000;
  localparam int IDX_W = ADDR_W - SEC_SHIFT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [IDX_W-1:0] s_idx = '0;
  logic s_ready, bus_we, bus_oe, done, err, gap_viol;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  sector_erase_seq #(.ADDR_W(ADDR_W), .SEC_SHIFT(SEC_SHIFT), .GAP_LIM(GAP_LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_idx(s_idx), .s_last(s_last),
    .s_ready(s_ready), .bus_we(bus_we), .bus_oe(bus_oe), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done), .err(err), .gap_viol(gap_viol));

  // flash model
  logic busy = 1'b0, tog = 1'b0, dq5_on = 1'b0;
  int   rdc = 0, nsec = 0, busy_reads = 5, dq3_at = 0;
  wire  dq3 = (dq3_at != 0) && (nsec >= dq3_at);
  assign bus_rdata = busy ? {1'b0, tog, dq5_on, 1'b0, dq3, 3'b000} : 8'hFF;

  always @(posedge clk) begin
    if (bus_we && bus_wdata == 8'h30) begin
      nsec <= nsec + 1; busy <= 1'b1; rdc <= 0; tog <= 1'b0;
    end else if (bus_oe && busy) begin
      tog <= ~tog; rdc <= rdc + 1;
      if (rdc + 1 >= busy_reads) busy <= 1'b0;
    end
  end

  // scoreboard
  int n_cmp = 0, n_bad = 0, n_done = 0, n_err = 0, n_gap = 0;
  logic [ADDR_W+7:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic exp_cmd();
    expq.push_back({ADDR_W'(12'h555), 8'hAA});
    expq.push_back({ADDR_W'(12'h2AA), 8'h55});
    expq.push_back({ADDR_W'(12'h555), 8'h80});
    expq.push_back({ADDR_W'(12'h555), 8'hAA});
    expq.push_back({ADDR_W'(12'h2AA), 8'h55});
  endtask

  task automatic exp_sec(input int idx);
    expq.push_back({ADDR_W'(idx) << SEC_SHIFT, 8'h30});
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_we) begin
      logic [ADDR_W+7:0] e;
      if (expq.size() == 0) chk(1'b0, "R2/R3 unexpected write", int'({bus_addr, bus_wdata}), 0);
      else begin
        e = expq.pop_front();
        chk({bus_addr, bus_wdata} == e, "R2/R3 write", int'({bus_addr, bus_wdata}), int'(e));
      end
    end
    if (s_ready) chk(bus_we && bus_wdata == 8'h30, "R3 ready", int'(bus_wdata), 'h30);
    if (bus_we && bus_oe) chk(1'b0, "R11 strobes", 1, 0);
    if (done && err) chk(1'b0, "R11 flags", 1, 0);
    if (done) n_done++;
    if (err) n_err++;
    if (gap_viol) n_gap++;
  end

  task automatic put(input int idx, input bit last);
    s_valid = 1'b1; s_idx = IDX_W'(idx); s_last = last;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_end(input int d0, input int e0, input int tgt);
    int t = 0;
    while ((n_done + n_err) - (d0 + e0) < tgt && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int d0, e0, g0;
    repeat (3) @(negedge clk);
    chk(!bus_we && !bus_oe && !s_ready && !done && !err && !gap_viol, "R1 in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_we && !bus_oe && !s_ready && !done && !err && !gap_viol, "R1 after reset", 1, 0);

    // single sector, normal completion (R2 R3 R6)
    d0 = n_done; e0 = n_err; busy_reads = 5; dq5_on = 0; dq3_at = 0;
    exp_cmd(); exp_sec(3);
    put(3, 1'b1);
    wait_end(d0, e0, 1);
    chk(n_done - d0 == 1, "R6 done count", n_done - d0, 1);
    chk(n_err == e0, "R6 no err", n_err - e0, 0);
    chk(expq.size() == 0, "R2 queue empty", expq.size(), 0);

    // three sectors batched (R4)
    d0 = n_done; e0 = n_err;
    exp_cmd(); exp_sec(1); exp_sec(7); exp_sec(15);
    put(1, 1'b0); put(7, 1'b0); put(15, 1'b1);
    wait_end(d0, e0, 1);
    chk(n_done - d0 == 1, "R4 one erase", n_done - d0, 1);
    chk(expq.size() == 0, "R4 batch writes", expq.size(), 0);

    // window closes after second sector; third reissued (R5 R7)
    d0 = n_done; e0 = n_err; dq3_at = nsec + 2;
    exp_cmd(); exp_sec(2); exp_sec(5); exp_cmd(); exp_sec(9);
    put(2, 1'b0); put(5, 1'b0); put(9, 1'b1);
    wait_end(d0, e0, 2);
    dq3_at = 0;
    chk(n_done - d0 == 2, "R7 two erases", n_done - d0, 2);
    chk(expq.size() == 0, "R5 pending reissued", expq.size(), 0);

    // failure confirmed (R8)
    d0 = n_done; e0 = n_err; dq5_on = 1; busy_reads = 1000;
    exp_cmd(); exp_sec(4);
    put(4, 1'b1);
    wait_end(d0, e0, 1);
    chk(n_err - e0 == 1, "R8 err pulse", n_err - e0, 1);
    chk(n_done == d0, "R8 no done", n_done - d0, 0);

    // failure bit but toggle stops at confirm read (R9)
    d0 = n_done; e0 = n_err; busy_reads = 2;
    exp_cmd(); exp_sec(6);
    put(6, 1'b1);
    wait_end(d0, e0, 1);
    chk(n_done - d0 == 1, "R9 done", n_done - d0, 1);
    chk(n_err == e0, "R9 no err", n_err - e0, 0);
    dq5_on = 0;

    // idle window too long (R10), then new sequence (R7)
    d0 = n_done; e0 = n_err; g0 = n_gap; busy_reads = 3000;
    exp_cmd(); exp_sec(8);
    put(8, 1'b0);
    wait_end(d0, e0, 1);
    chk(n_gap - g0 == 1, "R10 gap pulse", n_gap - g0, 1);
    chk(n_done - d0 == 1, "R10 done after gap", n_done - d0, 1);
    d0 = n_done; busy_reads = 5;
    exp_cmd(); exp_sec(11);
    put(11, 1'b1);
    wait_end(d0, e0, 1);
    chk(n_done - d0 == 1, "R7 restart done", n_done - d0, 1);
    chk(expq.size() == 0, "R10 writes", expq.size(), 0);
    chk(n_gap - g0 == 1, "R10 single gap", n_gap - g0, 1);

    summary();
  end
endmodule